// File: doc/BRIEF.md
# Static Dataflow Instruction Firing Unit

This block is a small token-driven execution engine. It holds an array of instruction templates. Each template has an opcode, an immediate, two operand slots with a presence flag each, and two destination fields. No program counter is involved. A template becomes eligible when its operands have arrived. It runs only if every slot it would write inside the array is empty, so each arc carries at most one token at a time.

A program is written into the template array through a load port. Input values then arrive as tokens on the token port. A token names a template, a side (left or right) and a value. When a template fires, a small integer ALU computes the result. A copy goes into each internal destination slot. If any destination is marked external, the value also appears on the result port. One template fires per cycle at most, and ready templates share the firing slot in rotating order.

The template count must be a power of two.

Top module: `sdf_fire_unit`

## Requirements
- R1: After synchronous reset, `fire_valid`, `res_valid` and `err` are 0 and every operand slot is empty, so the first token sent to any slot is accepted without raising `err`.
- R2: A template whose opcode needs two operands (codes 0, 1, 2) fires only once both its left and right slots hold a token. Opcode 3 fires as soon as its left slot holds a token.
- R3: A template does not fire while any enabled internal destination slot still holds a token. Destinations that are disabled or marked external never block firing.
- R4: Firing consumes the operands. It empties the firing template's left slot, and its right slot too when the opcode uses it, so new tokens to those slots are accepted without error.
- R5: The ALU computes modulo 2^DATA_W as follows. Opcode 0 gives left+right. Opcode 1 gives left-right. Opcode 2 gives left*right. Opcode 3 gives left*immediate.
- R6: A token addressed to a slot that already holds a token, or to a slot being filled by a firing in the same cycle, is dropped. `err` is then 1 in the following cycle, and the slot keeps its earlier value.
- R7: Each destination field is decoded as follows. Bit IDX_W+2 enables it. Bit IDX_W+1 marks it external. Bits IDX_W:1 give the template index, and bit 0 gives the port (0 = left, 1 = right). A firing writes its result into every enabled internal destination slot.
- R8: The firing is reported one cycle after it is selected: `fire_valid` is 1 and `fire_idx` gives the template. `res_valid`/`res_data` carry the result in that same cycle only if at least one destination is enabled and external.
- R9: At most one template fires per cycle. The search for a ready template starts at the index after the last one fired and wraps around.
- R10: A load writes the opcode, immediate and both destinations of one template, and empties both of its operand slots.
- R11: Timing is as follows. A token is written at the clock edge where it is presented. If that completes a ready template, the template fires at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one template |
| ld_idx | input | IDX_W | Template being loaded |
| ld_op | input | 2 | Opcode (0 add, 1 sub, 2 mul, 3 mul-immediate) |
| ld_imm | input | DATA_W | Immediate operand |
| ld_dst0 | input | IDX_W+3 | First destination field |
| ld_dst1 | input | IDX_W+3 | Second destination field |
| tok_valid | input | 1 | Token present |
| tok_idx | input | IDX_W | Target template |
| tok_port | input | 1 | Target slot, 0 left, 1 right |
| tok_data | input | DATA_W | Token value |
| fire_valid | output | 1 | A template fired |
| fire_idx | output | IDX_W | Template that fired |
| res_valid | output | 1 | External result present |
| res_data | output | DATA_W | Result value |
| err | output | 1 | Token dropped on an occupied slot |

## Verification
The assertions check several properties on every cycle. A selected template must have its required operands present and both internal destination slots empty. A firing must empty the slots it consumed. A token sent to an occupied slot must raise `err`, and a result must never appear without a firing. The arithmetic of every opcode over edge-value operands, multi-stage graph evaluation and the round-robin firing order can only be shown by the bench. The same holds for a blocked template resuming after its consumer fires, and for a dropped token leaving the earlier value in place.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int DEF_N_TPL  = 8;
    localparam int DEF_DATA_W = 16;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_MULI = 2'd3
    } sdf_op_e;

    // True when the opcode consumes the right operand slot.
    function automatic logic op_needs_right(input sdf_op_e op);
        return op != OP_MULI;
    endfunction

endpackage

// File: rtl/sdf_rr_pick.sv
module sdf_rr_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          gnt_v,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] cand;

    // Scan from the far end back so the candidate closest to ptr wins.
    always_comb begin
        gnt_v   = 1'b0;
        gnt_idx = ptr;
        cand    = ptr;
        for (int k = N - 1; k >= 0; k--) begin
            cand = ptr + IW'(k);
            if (req[cand]) begin
                gnt_v   = 1'b1;
                gnt_idx = cand;
            end
        end
    end
endmodule

// File: rtl/sdf_alu.sv
module sdf_alu
    import sdf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sdf_op_e           op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = lhs + rhs;
            OP_SUB:  y = lhs - rhs;
            OP_MUL:  y = lhs * rhs;
            OP_MULI: y = lhs * imm;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/sdf_fire_unit.sv
module sdf_fire_unit
    import sdf_pkg::*;
#(
    parameter int  N_TPL  = DEF_N_TPL,
    parameter int  DATA_W = DEF_DATA_W,
    localparam int IDX_W  = $clog2(N_TPL),
    localparam int DST_W  = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [1:0]        ld_op,
    input  logic [DATA_W-1:0] ld_imm,
    input  logic [DST_W-1:0]  ld_dst0,
    input  logic [DST_W-1:0]  ld_dst1,
    input  logic              tok_valid,
    input  logic [IDX_W-1:0]  tok_idx,
    input  logic              tok_port,
    input  logic [DATA_W-1:0] tok_data,
    output logic              fire_valid,
    output logic [IDX_W-1:0]  fire_idx,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              err
);
    typedef struct packed {
        logic             en;
        logic             ext;
        logic [IDX_W-1:0] idx;
        logic             port;
    } dest_t;

    typedef struct packed {
        sdf_op_e           op;
        logic [DATA_W-1:0] imm;
        dest_t             d0;
        dest_t             d1;
    } tpl_t;

    tpl_t              tpl_q  [N_TPL];
    logic [DATA_W-1:0] lval_q [N_TPL];
    logic [DATA_W-1:0] rval_q [N_TPL];
    logic [N_TPL-1:0]  lpres_q, rpres_q;
    logic [N_TPL-1:0]  ready;
    logic [IDX_W-1:0]  ptr_q;

    logic              sel_v;
    logic [IDX_W-1:0]  sel_idx;
    tpl_t              sel_t;
    dest_t             sel_d [2];
    logic [DATA_W-1:0] alu_y;
    logic              ext_any;
    logic              tok_full, tok_hit, tok_bad;

    // Per-template enable: operands present and every internal arc empty.
    for (genvar i = 0; i < N_TPL; i++) begin : g_rdy
        dest_t a0, a1;
        logic  free0, free1, ops;
        assign a0    = tpl_q[i].d0;
        assign a1    = tpl_q[i].d1;
        assign free0 = !a0.en || a0.ext ||
                       !(a0.port ? rpres_q[a0.idx] : lpres_q[a0.idx]);
        assign free1 = !a1.en || a1.ext ||
                       !(a1.port ? rpres_q[a1.idx] : lpres_q[a1.idx]);
        assign ops   = lpres_q[i] && (!op_needs_right(tpl_q[i].op) || rpres_q[i]);
        assign ready[i] = ops && free0 && free1;
    end

    sdf_rr_pick #(.N(N_TPL), .IW(IDX_W)) u_pick (
        .req     (ready),
        .ptr     (ptr_q),
        .gnt_v   (sel_v),
        .gnt_idx (sel_idx)
    );

    assign sel_t    = tpl_q[sel_idx];
    assign sel_d[0] = sel_t.d0;
    assign sel_d[1] = sel_t.d1;
    assign ext_any  = (sel_t.d0.en && sel_t.d0.ext) || (sel_t.d1.en && sel_t.d1.ext);

    sdf_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (sel_t.op),
        .lhs (lval_q[sel_idx]),
        .rhs (rval_q[sel_idx]),
        .imm (sel_t.imm),
        .y   (alu_y)
    );

    // Token acceptance: reject an occupied slot or one a firing fills now.
    always_comb begin
        tok_full = tok_port ? rpres_q[tok_idx] : lpres_q[tok_idx];
        tok_hit  = 1'b0;
        for (int j = 0; j < 2; j++) begin
            if (sel_v && sel_d[j].en && !sel_d[j].ext &&
                sel_d[j].idx == tok_idx && sel_d[j].port == tok_port)
                tok_hit = 1'b1;
        end
        tok_bad = tok_valid && (tok_full || tok_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lpres_q    <= '0;
            rpres_q    <= '0;
            ptr_q      <= '0;
            fire_valid <= 1'b0;
            fire_idx   <= '0;
            res_valid  <= 1'b0;
            res_data   <= '0;
            err        <= 1'b0;
            for (int i = 0; i < N_TPL; i++) begin
                tpl_q[i]  <= '0;
                lval_q[i] <= '0;
                rval_q[i] <= '0;
            end
        end else begin
            fire_valid <= sel_v;
            fire_idx   <= sel_idx;
            res_valid  <= sel_v && ext_any;
            res_data   <= alu_y;
            err        <= tok_bad;

            if (sel_v) begin
                ptr_q            <= sel_idx + IDX_W'(1);
                lpres_q[sel_idx] <= 1'b0;
                rpres_q[sel_idx] <= 1'b0;
                for (int j = 0; j < 2; j++) begin
                    if (sel_d[j].en && !sel_d[j].ext) begin
                        if (sel_d[j].port) begin
                            rval_q[sel_d[j].idx]  <= alu_y;
                            rpres_q[sel_d[j].idx] <= 1'b1;
                        end else begin
                            lval_q[sel_d[j].idx]  <= alu_y;
                            lpres_q[sel_d[j].idx] <= 1'b1;
                        end
                    end
                end
            end

            if (tok_valid && !tok_bad) begin
                if (tok_port) begin
                    rval_q[tok_idx]  <= tok_data;
                    rpres_q[tok_idx] <= 1'b1;
                end else begin
                    lval_q[tok_idx]  <= tok_data;
                    lpres_q[tok_idx] <= 1'b1;
                end
            end

            if (ld_en) begin
                tpl_q[ld_idx].op  <= sdf_op_e'(ld_op);
                tpl_q[ld_idx].imm <= ld_imm;
                tpl_q[ld_idx].d0  <= dest_t'(ld_dst0);
                tpl_q[ld_idx].d1  <= dest_t'(ld_dst1);
                lpres_q[ld_idx]   <= 1'b0;
                rpres_q[ld_idx]   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdf_fire_unit_chk.sv
module sdf_fire_unit_chk #(
    parameter int  N_TPL  = 8,
    parameter int  DATA_W = 16,
    localparam int IW     = $clog2(N_TPL),
    localparam int DW     = IW + 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tok_valid,
    input logic [IW-1:0]    tok_idx,
    input logic             tok_port,
    input logic             err,
    input logic             fire_valid,
    input logic             res_valid,
    input logic [N_TPL-1:0] lpres,
    input logic [N_TPL-1:0] rpres,
    input logic             sel_v,
    input logic [IW-1:0]    sel_idx,
    input logic [1:0]       sel_op,
    input logic [DW-1:0]    sel_d0,
    input logic [DW-1:0]    sel_d1
);
    logic d0_int, d1_int, d0_full, d1_full;
    assign d0_int  = sel_d0[IW+2] && !sel_d0[IW+1];
    assign d1_int  = sel_d1[IW+2] && !sel_d1[IW+1];
    assign d0_full = sel_d0[0] ? rpres[sel_d0[IW:1]] : lpres[sel_d0[IW:1]];
    assign d1_full = sel_d1[0] ? rpres[sel_d1[IW:1]] : lpres[sel_d1[IW:1]];

    AST_FIRE_OPERANDS: assert property (@(posedge clk) disable iff (rst)
        sel_v |-> lpres[sel_idx] && (sel_op == 2'd3 || rpres[sel_idx])); // R2

    AST_ARC0_FREE: assert property (@(posedge clk) disable iff (rst)
        sel_v && d0_int |-> !d0_full); // R3

    AST_ARC1_FREE: assert property (@(posedge clk) disable iff (rst)
        sel_v && d1_int |-> !d1_full); // R3

    AST_FIRE_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        sel_v |=> !lpres[$past(sel_idx)] &&
                  ($past(sel_op) == 2'd3 || !rpres[$past(sel_idx)])); // R4

    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        tok_valid && (tok_port ? rpres[tok_idx] : lpres[tok_idx]) |=> err); // R6

    AST_RESULT_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> fire_valid); // R8
endmodule

bind sdf_fire_unit sdf_fire_unit_chk #(.N_TPL(N_TPL), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tok_valid  (tok_valid),
    .tok_idx    (tok_idx),
    .tok_port   (tok_port),
    .err        (err),
    .fire_valid (fire_valid),
    .res_valid  (res_valid),
    .lpres      (lpres_q),
    .rpres      (rpres_q),
    .sel_v      (sel_v),
    .sel_idx    (sel_idx),
    .sel_op     (sel_t.op),
    .sel_d0     (sel_t.d0),
    .sel_d1     (sel_t.d1)
);

// File: tb/sdf_fire_unit_test.sv
`timescale 1ns/1ps
module sdf_fire_unit_test;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int IW = 3;
    localparam int DW = IW + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [1:0]    ld_op = '0;
    logic [W-1:0]  ld_imm = '0;
    logic [DW-1:0] ld_dst0 = '0, ld_dst1 = '0;
    logic          tok_valid = 1'b0;
    logic [IW-1:0] tok_idx = '0;
    logic          tok_port = 1'b0;
    logic [W-1:0]  tok_data = '0;
    logic          fire_valid, res_valid, err;
    logic [IW-1:0] fire_idx;
    logic [W-1:0]  res_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    sdf_fire_unit #(.N_TPL(N), .DATA_W(W)) uut (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_op(ld_op), .ld_imm(ld_imm),
        .ld_dst0(ld_dst0), .ld_dst1(ld_dst1),
        .tok_valid(tok_valid), .tok_idx(tok_idx), .tok_port(tok_port), .tok_data(tok_data),
        .fire_valid(fire_valid), .fire_idx(fire_idx),
        .res_valid(res_valid), .res_data(res_data), .err(err)
    );

    function automatic logic [DW-1:0] dext();
        return {1'b1, 1'b1, {IW{1'b0}}, 1'b0};
    endfunction

    function automatic logic [DW-1:0] dint(input int idx, input bit port);
        return {1'b1, 1'b0, IW'(idx), port};
    endfunction

    function automatic logic [W-1:0] model(input int op, input logic [W-1:0] a, b);
        case (op)
            0: return a + b;
            1: return a - b;
            default: return a * b;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input int op, input logic [W-1:0] imm,
                        input logic [DW-1:0] d0, d1);
        ld_idx = IW'(idx); ld_op = 2'(op); ld_imm = imm; ld_dst0 = d0; ld_dst1 = d1;
        ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic send(input int idx, input bit port, input logic [W-1:0] v);
        tok_idx = IW'(idx); tok_port = port; tok_data = v; tok_valid = 1'b1;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) load(i, 0, '0, '0, '0);
    endtask

    task automatic wait_res(output bit got, output logic [W-1:0] v);
        got = 0; v = '0;
        for (int k = 0; k < 12 && !got; k++) begin
            @(negedge clk);
            if (res_valid) begin got = 1; v = res_data; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] vals [6];
        logic [W-1:0] v, x, y, exp;
        bit got;
        vals = '{16'h0000, 16'h0001, 16'h0007, 16'h7fff, 16'h8000, 16'hffff};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs idle after reset
        chk(!fire_valid && !res_valid && !err, "R1 idle outputs", {fire_valid, res_valid, err}, 0);
        send(0, 0, 16'h5);
        chk(!err, "R1 empty left slot", err, 0);
        send(3, 1, 16'h5);
        chk(!err, "R1 empty right slot", err, 0);
        clear_all();

        // R5 / R2 / R11: opcode sweep on template 0
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    load(0, op, vals[j], dext(), '0);
                    send(0, 0, vals[i]);
                    if (op != 3) begin
                        send(0, 1, vals[j]);
                        chk(!fire_valid, "R2 waits for right operand", fire_valid, 0);
                    end
                    @(negedge clk);
                    exp = model(op, vals[i], vals[j]);
                    chk(res_valid && res_data == exp, "R5 alu result", {res_valid, res_data}, {1'b1, exp});
                end
            end
        end

        // R7: graph (x-y)*(x+y), x=a+b, y=7b
        clear_all();
        load(1, 0, '0, dint(3, 0), dint(4, 0));
        load(2, 3, 16'd7, dint(3, 1), dint(4, 1));
        load(3, 1, '0, dint(5, 0), '0);
        load(4, 0, '0, dint(5, 1), '0);
        load(5, 2, '0, dext(), '0);
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j += 2) begin
                send(1, 0, vals[i]);
                send(1, 1, vals[j]);
                send(2, 0, vals[j]);
                wait_res(got, v);
                x = vals[i] + vals[j];
                y = vals[j] * 16'd7;
                exp = (x - y) * (x + y);
                chk(got && v == exp, "R7 graph result", {got, v}, {1'b1, exp});
            end
        end

        // R3: producer blocked while consumer slot is occupied
        clear_all();
        load(0, 0, '0, dint(1, 0), '0);
        load(1, 0, '0, dext(), '0);
        send(0, 0, 16'd3);
        send(0, 1, 16'd4);
        @(negedge clk);
        chk(fire_valid && fire_idx == 0, "R8 producer fires", {fire_valid, fire_idx}, {1'b1, 3'd0});
        send(0, 0, 16'd10);
        send(0, 1, 16'd20);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!fire_valid, "R3 blocked on full arc", fire_valid, 0);
        end
        send(1, 1, 16'd100);
        @(negedge clk);
        chk(res_valid && res_data == 16'd107 && fire_idx == 1, "R3 consumer result",
            {res_valid, fire_idx, res_data}, {1'b1, 3'd1, 16'd107});
        @(negedge clk);
        chk(fire_valid && fire_idx == 0 && !res_valid, "R3 producer resumes",
            {fire_valid, fire_idx, res_valid}, {1'b1, 3'd0, 1'b0});
        send(1, 1, 16'd1);
        @(negedge clk);
        chk(res_valid && res_data == 16'd31, "R3 second result", res_data, 16'd31);

        // R6: token into occupied slot is dropped
        clear_all();
        load(0, 0, '0, dext(), '0);
        send(0, 0, 16'd5);
        chk(!err, "R6 first token accepted", err, 0);
        send(0, 0, 16'd9);
        chk(err, "R6 error flagged", err, 1);
        send(0, 1, 16'd1);
        chk(!err, "R6 error is one cycle", err, 0);
        @(negedge clk);
        chk(res_valid && res_data == 16'd6, "R6 old value kept", res_data, 16'd6);

        // R4: slots empty after firing
        send(0, 0, 16'd2);
        chk(!err, "R4 left reusable", err, 0);
        send(0, 1, 16'd2);
        chk(!err, "R4 right reusable", err, 0);
        @(negedge clk);
        chk(res_valid && res_data == 16'd4, "R4 refire result", res_data, 16'd4);

        // R10: loading empties slots
        send(0, 0, 16'd5);
        load(0, 0, '0, dext(), '0);
        send(0, 0, 16'd6);
        chk(!err, "R10 load cleared slot", err, 0);
        send(0, 1, 16'd1);
        @(negedge clk);
        chk(res_valid && res_data == 16'd7, "R10 result after load", res_data, 16'd7);

        // R9: round-robin order, two templates ready together
        clear_all();
        load(5, 0, '0, dint(6, 0), dint(2, 0));
        load(6, 0, '0, dext(), '0);
        load(2, 0, '0, dext(), '0);
        send(6, 1, 16'd1);
        send(2, 1, 16'd2);
        send(5, 0, 16'd3);
        send(5, 1, 16'd4);
        @(negedge clk);
        chk(fire_valid && fire_idx == 5 && !res_valid, "R8 internal-only no result",
            {fire_valid, fire_idx, res_valid}, {1'b1, 3'd5, 1'b0});
        @(negedge clk);
        chk(fire_idx == 6 && res_valid && res_data == 16'd8, "R9 next after last fired",
            {fire_idx, res_data}, {3'd6, 16'd8});
        @(negedge clk);
        chk(fire_idx == 2 && res_valid && res_data == 16'd9, "R9 lower index later",
            {fire_idx, res_data}, {3'd2, 16'd9});

        clear_all();
        load(1, 0, '0, dint(3, 0), dint(0, 0));
        load(3, 0, '0, dext(), '0);
        load(0, 0, '0, dext(), '0);
        send(3, 1, 16'd10);
        send(0, 1, 16'd20);
        send(1, 0, 16'd1);
        send(1, 1, 16'd2);
        @(negedge clk);
        chk(fire_valid && fire_idx == 1, "R9 source fires", fire_idx, 1);
        @(negedge clk);
        chk(fire_idx == 3 && res_data == 16'd13, "R9 search from pointer", {fire_idx, res_data}, {3'd3, 16'd13});
        @(negedge clk);
        chk(fire_idx == 0 && res_data == 16'd23, "R9 wraparound", {fire_idx, res_data}, {3'd0, 16'd23});
        @(negedge clk);
        chk(!fire_valid, "R9 single firing each", fire_valid, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule